// File: doc/BRIEF.md
# BCD Real-Time Clock with Frozen Host View

This block is a real-time clock core. It keeps hundredths of a second, seconds, minutes, hours, day of week, date, month and two-digit year, all in packed BCD. A 100 Hz enable input advances the clock. A 2048 Hz enable input produces a 1024 Hz square wave. A host reaches the registers through a small parallel bus with a 4-bit address, 8-bit write data, write and read strobes, and combinational read data.

The time is held twice. The internal copy advances on every active tick. The host sees a second copy. That copy follows the internal one while the transfer control bit is set. When the host clears the bit, the host copy stops changing, so a multi-byte read or write cannot be torn by a carry. Because the internal copy keeps counting, no time is lost while the view is frozen. The hundredths field is copied on every tick. All the other fields are copied only on the tick in which hundredths wraps from 99 to 00.

The register map, with every encoding the host relies on:
- Address 0: hundredths.
- Address 1: seconds (bits 6:0).
- Address 2: minutes (bits 6:0).
- Address 3: hours. Bit 6 is the mode bit, and 1 selects 12-hour mode. Bit 5 is the PM flag in 12-hour mode and the tens-of-hours "2" in 24-hour mode.
- Address 4: day of week 1 to 7 (bits 2:0).
- Address 5: date (bits 5:0).
- Address 6: month and control. Bit 7 is the oscillator-stop bit. Bit 6 is the square-wave-off bit. Bits 4:0 hold the month.
- Address 7: year.
- Address 0xB: command. Bit 7 is the transfer bit.

All other addresses read as zero.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the registers read as follows. Addresses 0 to 3 read 0x00. Day reads 0x01, date reads 0x01, month reads 0xC1 (oscillator stopped, square wave off), year reads 0x00 and command reads 0x80. sqw_oe is 0.
- R2: While month bit 7 is 0, each tick_100hz pulse adds one to hundredths in BCD, and 99 wraps to 00 with a carry into seconds.
- R3: Seconds and minutes wrap from 59 to 00 with a carry. In 24-hour mode (hours bit 6 = 0), hours count 00 to 23, and 23 wraps to 00 with a carry into day and date. Day counts 1 to 7 and wraps from 7 to 1.
- R4: In 12-hour mode (hours bit 6 = 1), hours run 12, 01 … 11. The PM flag (hours bit 5) toggles on 11→12. A carry into the day happens only on 11 PM → 12 AM.
- R5: Date wraps to 01 after the last day of the month, with a carry into month. The last day is 28 for February, or 29 when the year is a multiple of 4 (year 00 included). It is 30 for months 04, 06, 09 and 11, and 31 for the rest. Month 12 wraps to 01 with a carry into year, and year 99 wraps to 00.
- R6: While month bit 7 is 1, tick_100hz changes no time field, and the square wave does not toggle.
- R7: While command bit 7 is 0, the host-visible time holds and the internal count keeps advancing. While the bit is 1, the visible hundredths takes the internal value on each tick. The other visible fields take the internal values on each hundredths 99→00 wrap.
- R8: A host write to a time register updates both the visible and the internal copy, including while frozen. Later counting starts from the written value.
- R9: Bits with no function read 0 whatever was written:
  - seconds, minutes and hours bit 7;
  - day bits 7:3;
  - date bits 7:6;
  - month bit 5;
  - command bits 6:0.
  
  Unused addresses read 0x00, and rdata is 0x00 while rd_en is low.
- R10: sqw_oe is the inverse of month bit 6. sqw toggles on each tick_2048 pulse while the oscillator runs, which gives 1024 Hz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100hz | input | 1 | One-cycle enable at 100 Hz |
| tick_2048 | input | 1 | One-cycle enable at 2048 Hz |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, combinational |
| sqw | output | 1 | 1024 Hz square wave |
| sqw_oe | output | 1 | Square-wave output enable |

## Verification
Some properties are checked on every cycle:
- The frozen view holds whenever no write occurs.
- The internal count holds while the oscillator is stopped.
- Visible hundredths matches internal hundredths after each tick with transfer on.
- Each running tick changes hundredths.
- The square wave and its enable react only to their own controls.
- Dead day bits read zero.

Only the bench scenarios can show the rest, against a behavioural model:
- the full carry chain, 12-hour PM handling, month lengths and leap years;
- the deferred copy of seconds and above after unfreezing;
- a write made while frozen persisting into the internal count.

// File: rtl/bcd_rtc.sv
module bcd_rtc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_100hz,
  input  logic       tick_2048,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata,
  output logic       sqw,
  output logic       sqw_oe
);

  logic [7:0] i_hs, e_hs, i_yr, e_yr;
  logic [6:0] i_sc, e_sc, i_mn, e_mn, i_hr, e_hr;
  logic [2:0] i_dy, e_dy;
  logic [5:0] i_dt, e_dt;
  logic [4:0] i_mo, e_mo;
  logic       osc_n, sqw_n, te, sq;

  logic [7:0] n_hs, n_yr, hs_inc, yr_inc;
  logic [6:0] n_sc, n_mn, n_hr, sc_inc, mn_inc, hr_nx;
  logic [5:0] n_dt, dt_inc, hr24_inc, dim;
  logic [4:0] n_mo, mo_inc, hr12_inc;
  logic [2:0] n_dy;
  logic       run, roll, c_sc, c_mn, c_hr, c_dt, c_mo, hr_wrap, leap;
  logic [7:0] rv;

  assign run  = tick_100hz & ~osc_n;
  assign roll = (i_hs == 8'h99);

  assign hs_inc   = (i_hs[3:0] == 4'h9) ? {i_hs[7:4] + 4'd1, 4'h0} : i_hs + 8'd1;
  assign sc_inc   = (i_sc[3:0] == 4'h9) ? {i_sc[6:4] + 3'd1, 4'h0} : i_sc + 7'd1;
  assign mn_inc   = (i_mn[3:0] == 4'h9) ? {i_mn[6:4] + 3'd1, 4'h0} : i_mn + 7'd1;
  assign hr24_inc = (i_hr[3:0] == 4'h9) ? {i_hr[5:4] + 2'd1, 4'h0} : i_hr[5:0] + 6'd1;
  assign hr12_inc = (i_hr[3:0] == 4'h9) ? {i_hr[4] + 1'b1, 4'h0} : i_hr[4:0] + 5'd1;
  assign dt_inc   = (i_dt[3:0] == 4'h9) ? {i_dt[5:4] + 2'd1, 4'h0} : i_dt + 6'd1;
  assign mo_inc   = (i_mo[3:0] == 4'h9) ? {i_mo[4] + 1'b1, 4'h0} : i_mo + 5'd1;
  assign yr_inc   = (i_yr[3:0] == 4'h9) ? {i_yr[7:4] + 4'd1, 4'h0} : i_yr + 8'd1;

  always_comb begin
    hr_wrap = 1'b0;
    if (i_hr[6]) begin
      if (i_hr[4:0] == 5'h12) begin
        hr_nx = {i_hr[6:5], 5'h01};
      end else if (i_hr[4:0] == 5'h11) begin
        hr_nx   = {1'b1, ~i_hr[5], 5'h12};
        hr_wrap = i_hr[5];
      end else begin
        hr_nx = {i_hr[6:5], hr12_inc};
      end
    end else if (i_hr[5:0] == 6'h23) begin
      hr_nx   = 7'h00;
      hr_wrap = 1'b1;
    end else begin
      hr_nx = {1'b0, hr24_inc};
    end
  end

  assign leap = i_yr[4] ? (i_yr[3:0] == 4'h2 || i_yr[3:0] == 4'h6)
                        : (i_yr[3:0] == 4'h0 || i_yr[3:0] == 4'h4 || i_yr[3:0] == 4'h8);

  always_comb begin
    case (i_mo)
      5'h02:                      dim = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: dim = 6'h30;
      default:                    dim = 6'h31;
    endcase
  end

  assign c_sc = roll & (i_sc == 7'h59);
  assign c_mn = c_sc & (i_mn == 7'h59);
  assign c_hr = c_mn & hr_wrap;
  assign c_dt = c_hr & (i_dt == dim);
  assign c_mo = c_dt & (i_mo == 5'h12);

  assign n_hs = roll ? 8'h00 : hs_inc;
  assign n_sc = roll ? ((i_sc == 7'h59) ? 7'h00 : sc_inc) : i_sc;
  assign n_mn = c_sc ? ((i_mn == 7'h59) ? 7'h00 : mn_inc) : i_mn;
  assign n_hr = c_mn ? hr_nx : i_hr;
  assign n_dy = c_hr ? ((i_dy == 3'd7) ? 3'd1 : i_dy + 3'd1) : i_dy;
  assign n_dt = c_hr ? ((i_dt == dim) ? 6'h01 : dt_inc) : i_dt;
  assign n_mo = c_dt ? ((i_mo == 5'h12) ? 5'h01 : mo_inc) : i_mo;
  assign n_yr = c_mo ? ((i_yr == 8'h99) ? 8'h00 : yr_inc) : i_yr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_hs <= 8'h00; i_sc <= 7'h00; i_mn <= 7'h00; i_hr <= 7'h00;
      i_dy <= 3'd1;  i_dt <= 6'h01; i_mo <= 5'h01; i_yr <= 8'h00;
      e_hs <= 8'h00; e_sc <= 7'h00; e_mn <= 7'h00; e_hr <= 7'h00;
      e_dy <= 3'd1;  e_dt <= 6'h01; e_mo <= 5'h01; e_yr <= 8'h00;
      osc_n <= 1'b1; sqw_n <= 1'b1; te <= 1'b1; sq <= 1'b0;
    end else begin
      if (tick_2048 && !osc_n) sq <= ~sq;
      if (run) begin
        i_hs <= n_hs; i_sc <= n_sc; i_mn <= n_mn; i_hr <= n_hr;
        i_dy <= n_dy; i_dt <= n_dt; i_mo <= n_mo; i_yr <= n_yr;
        if (te) begin
          e_hs <= n_hs;
          if (roll) begin
            e_sc <= n_sc; e_mn <= n_mn; e_hr <= n_hr; e_dy <= n_dy;
            e_dt <= n_dt; e_mo <= n_mo; e_yr <= n_yr;
          end
        end
      end
      if (wr_en) begin
        case (addr)
          4'h0: begin i_hs <= wdata;      e_hs <= wdata;      end
          4'h1: begin i_sc <= wdata[6:0]; e_sc <= wdata[6:0]; end
          4'h2: begin i_mn <= wdata[6:0]; e_mn <= wdata[6:0]; end
          4'h3: begin i_hr <= wdata[6:0]; e_hr <= wdata[6:0]; end
          4'h4: begin i_dy <= wdata[2:0]; e_dy <= wdata[2:0]; end
          4'h5: begin i_dt <= wdata[5:0]; e_dt <= wdata[5:0]; end
          4'h6: begin
            i_mo <= wdata[4:0]; e_mo <= wdata[4:0];
            osc_n <= wdata[7];  sqw_n <= wdata[6];
          end
          4'h7: begin i_yr <= wdata;      e_yr <= wdata;      end
          4'hB: te <= wdata[7];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      4'h0:    rv = e_hs;
      4'h1:    rv = {1'b0, e_sc};
      4'h2:    rv = {1'b0, e_mn};
      4'h3:    rv = {1'b0, e_hr};
      4'h4:    rv = {5'b0, e_dy};
      4'h5:    rv = {2'b0, e_dt};
      4'h6:    rv = {osc_n, sqw_n, 1'b0, e_mo};
      4'h7:    rv = e_yr;
      4'hB:    rv = {te, 7'b0};
      default: rv = 8'h00;
    endcase
  end

  assign rdata  = rd_en ? rv : 8'h00;
  assign sqw    = sq;
  assign sqw_oe = ~sqw_n;

endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_100hz,
  input logic        tick_2048,
  input logic        wr_en,
  input logic [3:0]  addr,
  input logic        wd6,
  input logic        rd_en,
  input logic [4:0]  rdata_hi,
  input logic        sqw,
  input logic        sqw_oe,
  input logic        te,
  input logic        osc_n,
  input logic [50:0] int_time,
  input logic [50:0] ext_time,
  input logic [7:0]  int_hs,
  input logic [7:0]  ext_hs
);

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!te && !wr_en) |=> $stable(ext_time)); // R7

  AST_COPY_HUND: assert property (@(posedge clk) disable iff (!rst_n)
    (te && tick_100hz && !osc_n && !wr_en) |=> (ext_hs == int_hs)); // R7

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_n && !wr_en) |=> $stable(int_time)); // R6

  AST_RUN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_100hz && !osc_n && !wr_en) |=> (int_hs != $past(int_hs))); // R2

  AST_SQW_OE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h6) |=> (sqw_oe == !$past(wd6))); // R10

  AST_SQW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_2048 || osc_n) |=> $stable(sqw)); // R10

  AST_DAY_DEAD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'h4) |-> (rdata_hi == 5'b0)); // R9

endmodule

bind bcd_rtc bcd_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .tick_2048(tick_2048),
  .wr_en(wr_en), .addr(addr), .wd6(wdata[6]), .rd_en(rd_en),
  .rdata_hi(rdata[7:3]), .sqw(sqw), .sqw_oe(sqw_oe), .te(te), .osc_n(osc_n),
  .int_time({i_hs, i_sc, i_mn, i_hr, i_dy, i_dt, i_mo, i_yr}),
  .ext_time({e_hs, e_sc, e_mn, e_hr, e_dy, e_dt, e_mo, e_yr}),
  .int_hs(i_hs), .ext_hs(e_hs)
);

// File: tb/bcd_rtc_tb.sv
module bcd_rtc_tb;
  logic clk = 0, rst_n = 0, tick_100hz = 0, tick_2048 = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic wr_en = 0, rd_en = 1;
  logic [7:0] rdata;
  logic sqw, sqw_oe;
  int n_chk = 0, n_fail = 0;
  logic [3:0] scan = 0;

  always #4 clk = ~clk;

  bcd_rtc u_dut (.clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .tick_2048(tick_2048),
    .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .sqw(sqw), .sqw_oe(sqw_oe));

  int ih, isec, imin, ihr, iday, idate, imon, iyr;
  int eh, esec, emin, ehr, eday, edate, emon, eyr;
  bit m12, m_oscn, m_sqwn, m_te, m_sq;

  function automatic logic [7:0] tb(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int fb(logic [7:0] d);
    return int'(d[7:4]) * 10 + int'(d[3:0]);
  endfunction

  function automatic int dim(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task mreset;
    ih = 0; isec = 0; imin = 0; ihr = 0; iday = 1; idate = 1; imon = 1; iyr = 0;
    eh = 0; esec = 0; emin = 0; ehr = 0; eday = 1; edate = 1; emon = 1; eyr = 0;
    m12 = 0; m_oscn = 1; m_sqwn = 1; m_te = 1; m_sq = 0;
  endtask

  task mtick;
    if (ih == 99) begin
      ih = 0; isec++;
      if (isec == 60) begin
        isec = 0; imin++;
        if (imin == 60) begin
          imin = 0; ihr++;
          if (ihr == 24) begin
            ihr = 0; iday = (iday == 7) ? 1 : iday + 1; idate++;
            if (idate > dim(imon, iyr)) begin
              idate = 1; imon++;
              if (imon == 13) begin imon = 1; iyr = (iyr + 1) % 100; end
            end
          end
        end
      end
      if (m_te) begin
        eh = ih; esec = isec; emin = imin; ehr = ihr;
        eday = iday; edate = idate; emon = imon; eyr = iyr;
      end
    end else begin
      ih++;
      if (m_te) eh = ih;
    end
  endtask

  task mwrite(logic [3:0] a, logic [7:0] d);
    case (a)
      4'h0: begin ih = fb(d); eh = ih; end
      4'h1: begin isec = fb(d & 8'h7F); esec = isec; end
      4'h2: begin imin = fb(d & 8'h7F); emin = imin; end
      4'h3: begin
        m12 = d[6];
        ihr = m12 ? (fb(d & 8'h1F) % 12 + (d[5] ? 12 : 0)) : fb(d & 8'h3F);
        ehr = ihr;
      end
      4'h4: begin iday = int'(d[2:0]); eday = iday; end
      4'h5: begin idate = fb(d & 8'h3F); edate = idate; end
      4'h6: begin m_oscn = d[7]; m_sqwn = d[6]; imon = fb(d & 8'h1F); emon = imon; end
      4'h7: begin iyr = fb(d); eyr = iyr; end
      4'hB: m_te = d[7];
      default: ;
    endcase
  endtask

  function automatic logic [7:0] mread(logic [3:0] a);
    int h12;
    case (a)
      4'h0: return tb(eh);
      4'h1: return tb(esec);
      4'h2: return tb(emin);
      4'h3: begin
        if (!m12) return tb(ehr);
        h12 = ehr % 12;
        if (h12 == 0) h12 = 12;
        return 8'h40 | (ehr >= 12 ? 8'h20 : 8'h00) | tb(h12);
      end
      4'h4: return 8'(eday);
      4'h5: return tb(edate);
      4'h6: return {m_oscn, m_sqwn, 6'b0} | tb(emon);
      4'h7: return tb(eyr);
      4'hB: return {m_te, 7'b0};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) mreset();
    else begin
      if (tick_100hz && !m_oscn && !wr_en) mtick();
      if (tick_2048 && !m_oscn) m_sq = !m_sq;
      if (wr_en) mwrite(addr, wdata);
    end
  end

  task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all;
    logic [7:0] e;
    if (rd_en) begin
      e = mread(addr);
      chk(rdata == e, "R7 visible copy vs model", rdata, e);
    end
    chk(sqw == m_sq, "R10 sqw vs model", {7'b0, sqw}, {7'b0, m_sq});
    chk(sqw_oe == !m_sqwn, "R10 sqw_oe vs model", {7'b0, sqw_oe}, {7'b0, !m_sqwn});
  endtask

  task automatic step(bit w, logic [3:0] a, logic [7:0] d, bit tk, bit t2);
    @(negedge clk);
    compare_all();
    wr_en = w; wdata = d; tick_100hz = tk; tick_2048 = t2;
    if (w) addr = a;
    else begin addr = scan; scan = scan + 4'd1; end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    step(1, a, d, 0, 0);
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 1, 0);
  endtask

  task automatic rd_chk(logic [3:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    compare_all();
    wr_en = 0; tick_100hz = 0; tick_2048 = 0; addr = a;
    @(negedge clk);
    compare_all();
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic set_eod;
    wr(3, 8'h23); wr(2, 8'h59); wr(1, 8'h59); wr(0, 8'h99);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    rd_chk(4'h0, 8'h00, "R1 reset hundredths");
    rd_chk(4'h3, 8'h00, "R1 reset hours");
    rd_chk(4'h4, 8'h01, "R1 reset day");
    rd_chk(4'h5, 8'h01, "R1 reset date");
    rd_chk(4'h6, 8'hC1, "R1 reset month");
    rd_chk(4'h7, 8'h00, "R1 reset year");
    rd_chk(4'hB, 8'h80, "R1 reset command");
    chk(sqw_oe == 1'b0, "R1 reset sqw_oe", {7'b0, sqw_oe}, 8'h00);

    wr(6, 8'h01);
    ticks(5);
    rd_chk(4'h0, 8'h05, "R2 hundredths after 5 ticks");
    ticks(95);
    rd_chk(4'h0, 8'h00, "R2 hundredths wrap");
    rd_chk(4'h1, 8'h01, "R2 carry into seconds");

    wr(0, 8'h98); wr(1, 8'h59); wr(2, 8'h59); wr(3, 8'h23); wr(4, 8'h07);
    ticks(2);
    rd_chk(4'h1, 8'h00, "R3 seconds wrap");
    rd_chk(4'h2, 8'h00, "R3 minutes wrap");
    rd_chk(4'h3, 8'h00, "R3 hours 23 to 00");
    rd_chk(4'h4, 8'h01, "R3 day 7 to 1");
    rd_chk(4'h5, 8'h02, "R3 date carry");

    wr(3, 8'h51); wr(2, 8'h59); wr(1, 8'h59); wr(0, 8'h99); ticks(1);
    rd_chk(4'h3, 8'h72, "R4 11 AM to 12 PM");
    wr(2, 8'h59); wr(1, 8'h59); wr(0, 8'h99); ticks(1);
    rd_chk(4'h3, 8'h61, "R4 12 PM to 01 PM");
    wr(3, 8'h71); wr(2, 8'h59); wr(1, 8'h59); wr(0, 8'h99); ticks(1);
    rd_chk(4'h3, 8'h52, "R4 11 PM to 12 AM");
    rd_chk(4'h4, 8'h02, "R4 day carry at midnight");
    rd_chk(4'h5, 8'h03, "R4 date carry at midnight");

    wr(7, 8'h23); wr(6, 8'h02); wr(5, 8'h28); set_eod(); ticks(1);
    rd_chk(4'h5, 8'h01, "R5 Feb 28 non-leap wraps");
    rd_chk(4'h6, 8'h03, "R5 month to March");
    wr(7, 8'h24); wr(6, 8'h02); wr(5, 8'h28); set_eod(); ticks(1);
    rd_chk(4'h5, 8'h29, "R5 leap Feb 29");
    set_eod(); ticks(1);
    rd_chk(4'h5, 8'h01, "R5 leap Feb 29 wraps");
    wr(7, 8'h99); wr(6, 8'h12); wr(5, 8'h31); set_eod(); ticks(1);
    rd_chk(4'h7, 8'h00, "R5 year 99 to 00");
    rd_chk(4'h6, 8'h01, "R5 month 12 to 01");
    wr(6, 8'h04); wr(5, 8'h30); set_eod(); ticks(1);
    rd_chk(4'h6, 8'h05, "R5 April 30 wraps");

    wr(6, 8'h85);
    ticks(10);
    rd_chk(4'h0, 8'h00, "R6 stopped hundredths");
    rd_chk(4'h6, 8'h85, "R6 stop bit reads back");
    for (int k = 0; k < 2; k++) step(0, 0, 0, 0, 1);
    rd_chk(4'h0, 8'h00, "R6 still stopped");
    chk(sqw == 1'b0, "R6 sqw held while stopped", {7'b0, sqw}, 8'h00);
    wr(6, 8'h05);
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 1);
    rd_chk(4'h6, 8'h05, "R10 month control");
    chk(sqw == 1'b1, "R10 sqw after 3 toggles", {7'b0, sqw}, 8'h01);
    chk(sqw_oe == 1'b1, "R10 sqw_oe on", {7'b0, sqw_oe}, 8'h01);
    wr(6, 8'h45);
    rd_chk(4'h6, 8'h45, "R10 square wave off");
    chk(sqw_oe == 1'b0, "R10 sqw_oe off", {7'b0, sqw_oe}, 8'h00);
    wr(6, 8'h05);

    wr(0, 8'h00); wr(1, 8'h00);
    wr(4'hB, 8'h00);
    ticks(150);
    rd_chk(4'h0, 8'h00, "R7 frozen hundredths");
    rd_chk(4'h1, 8'h00, "R7 frozen seconds");
    wr(4'hB, 8'h80);
    ticks(1);
    rd_chk(4'h0, 8'h51, "R7 hundredths follows after unfreeze");
    rd_chk(4'h1, 8'h00, "R7 seconds wait for wrap");
    ticks(49);
    rd_chk(4'h0, 8'h00, "R7 hundredths at wrap");
    rd_chk(4'h1, 8'h02, "R7 seconds copied, no time lost");

    wr(4'hB, 8'h00);
    wr(2, 8'h30);
    rd_chk(4'h2, 8'h30, "R8 write visible while frozen");
    ticks(100);
    wr(4'hB, 8'h80);
    ticks(100);
    rd_chk(4'h2, 8'h30, "R8 internal took written minutes");
    rd_chk(4'h1, 8'h04, "R8 seconds after frozen write");

    wr(1, 8'hC5); rd_chk(4'h1, 8'h45, "R9 seconds bit 7");
    wr(4, 8'hFB); rd_chk(4'h4, 8'h03, "R9 day bits 7:3");
    wr(5, 8'hD5); rd_chk(4'h5, 8'h15, "R9 date bits 7:6");
    wr(6, 8'h25); rd_chk(4'h6, 8'h05, "R9 month bit 5");
    wr(3, 8'h92); rd_chk(4'h3, 8'h12, "R9 hours bit 7");
    wr(4'hB, 8'hFF); rd_chk(4'hB, 8'h80, "R9 command bits 6:0");
    rd_chk(4'h8, 8'h00, "R9 unused address 8");
    rd_chk(4'hF, 8'h00, "R9 unused address F");
    @(negedge clk);
    compare_all();
    rd_en = 0; addr = 4'h1;
    @(negedge clk);
    chk(rdata == 8'h00, "R9 rdata idle low", rdata, 8'h00);
    rd_en = 1;
    ticks(20);
    step(0, 0, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule